// File: doc/BRIEF.md
# Flat Carry-Lookahead Adder/Subtractor

This block adds or subtracts two 13-bit two's-complement operands in a single combinational pass. A one-bit operation select chooses the operation. For subtraction, every bit of the second operand is inverted, and the select bit is also fed in as the incoming carry. That forms the first operand plus the complement of the second plus one.

Every internal carry comes from one flat lookahead stage. Each carry is a single two-level AND-OR expression over the per-bit generate and propagate terms and the incoming carry. There are no carry groups and no second level of lookahead. The netlist is gate-level, so delays can be placed on the gates for a timing study without changing the function.

The block also reports a carry-out and a signed-overflow flag.

Top module: `cla_addsub`

## Requirements
- R1: With `sub`=0, {`carry_out`,`result`} equals `a`+`b` taken modulo 2^14.
- R2: With `sub`=1, `result` equals `a`−`b` taken modulo 2^13.
- R3: With `sub`=1, `carry_out` is 1 exactly when `a` >= `b` as unsigned values. A value of 0 means a borrow occurred.
- R4: `overflow` is 1 exactly when the signed result is out of range. This is when the sign bit 12 of `a` equals the sign bit 12 of the conditioned second operand (`b`, or ~`b` when subtracting), and bit 12 of `result` differs from them.
- R5: A carry ripples across all 13 bits in one evaluation: 0x1FFF+0x0001 gives `result`=0x0000 and `carry_out`=1.
- R6: Subtracting past zero borrows across all bits: 0x0000−0x0001 gives `result`=0x1FFF and `carry_out`=0.
- R7: Signed overflow is flagged at both ends of the range. 0x0FFF+0x0001 and 0x1000−0x0001 each set `overflow`=1.
- R8: For both operations, `result[0]` equals `a[0]` XOR `b[0]`.
- R9: With all inputs at zero, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 13 | First operand |
| b | input | 13 | Second operand |
| sub | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | 13 | Sum or difference |
| carry_out | output | 1 | Carry from bit 12 (inverse borrow when subtracting) |
| overflow | output | 1 | Signed overflow |

## Verification
Carry-out and signed overflow can be raised by the same input pair. Adding 0x1000 to 0x1000 sets both and yields zero. Subtracting 0x0001 from 0x1000 sets overflow while carry-out stays high. The bench applies such pairs directly and also meets them among random vectors. Both flags are judged together against a reference sum formed in bench functions, with overflow taken from operand and result signs, not from carries.

// File: rtl/cla_addsub.sv
module cla_addsub #(
  parameter int W = 13
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         overflow
);

  logic [W-1:0]        bx, g, p;
  logic [W:0]          c;
  logic [W:0]          ge;
  logic [W:0]          pe;
  logic [W-1:0][W:0]   term;

  assign c[0]  = sub;
  assign ge[0] = sub;
  assign pe[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    xor u_inv (bx[i], b[i], sub);
    and u_gen (g[i], a[i], bx[i]);
    xor u_prop (p[i], a[i], bx[i]);
    xor u_sum (result[i], p[i], c[i]);
    assign ge[i+1] = g[i];
    assign pe[i+1] = p[i];
  end

  for (genvar i = 0; i < W; i++) begin : g_carry
    for (genvar k = 0; k <= W; k++) begin : g_term
      if (k == i + 1) begin : g_own
        assign term[i][k] = ge[k];
      end else if (k <= i) begin : g_chain
        assign term[i][k] = ge[k] & (&pe[i+1:k+1]);
      end else begin : g_none
        assign term[i][k] = 1'b0;
      end
    end
    assign c[i+1] = |term[i];
  end

  assign carry_out = c[W];
  xor u_ovf (overflow, c[W], c[W-1]);

endmodule

// File: rtl/cla_addsub_props.sv
module cla_addsub_props #(
  parameter int W = 13
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         sub,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         overflow
);

  logic [W:0]   ref_sum;
  logic [W-1:0] ref_bx;

  always_comb begin
    ref_bx  = sub ? ~b : b;
    ref_sum = {1'b0, a} + {1'b0, ref_bx} + {{W{1'b0}}, sub};

    // R1
    a_r1_add_sum: assert (sub || {carry_out, result} == ref_sum)
      else $error("R1 add mismatch");
    // R2
    a_r2_sub_diff: assert (!sub || result == a - b)
      else $error("R2 sub mismatch");
    // R3
    a_r3_no_borrow: assert (!sub || carry_out == (a >= b))
      else $error("R3 borrow mismatch");
    // R4
    a_r4_signed_ovf: assert (overflow ==
        ((a[W-1] == ref_bx[W-1]) && (result[W-1] != a[W-1])))
      else $error("R4 overflow mismatch");
    // R8
    a_r8_low_bit: assert (result[0] == (a[0] ^ b[0]))
      else $error("R8 low bit mismatch");
  end

endmodule

bind cla_addsub cla_addsub_props #(.W(W)) u_props (
  .a(a), .b(b), .sub(sub),
  .result(result), .carry_out(carry_out), .overflow(overflow)
);

// File: tb/cla_addsub_test.sv
module cla_addsub_test;
  localparam int W = 13;
  localparam int PERIOD = 10;
  localparam int NRAND = 4000;

  logic clk = 1'b0;
  logic [W-1:0] a, b;
  logic sub;
  logic [W-1:0] result;
  logic carry_out, overflow;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  cla_addsub #(.W(W)) uut (
    .a(a), .b(b), .sub(sub),
    .result(result), .carry_out(carry_out), .overflow(overflow)
  );

  function automatic logic [W:0] exp_sum(logic [W-1:0] x, logic [W-1:0] y, logic s);
    logic [W-1:0] yy;
    yy = y ^ {W{s}};
    return {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, s};
  endfunction

  function automatic logic exp_ovf(logic [W-1:0] x, logic [W-1:0] y, logic s);
    logic [W-1:0] yy;
    logic [W:0] t;
    yy = y ^ {W{s}};
    t = exp_sum(x, y, s);
    return (x[W-1] == yy[W-1]) && (t[W-1] != x[W-1]);
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic s,
                       input string req);
    logic [W:0] es;
    logic eo;
    @(posedge clk);
    a = x; b = y; sub = s;
    @(negedge clk);
    es = exp_sum(x, y, s);
    eo = exp_ovf(x, y, s);
    checks++;
    if (result != es[W-1:0]) begin
      failures++;
      $display("FAIL %s result a=%h b=%h s=%0b actual=%h expected=%h", req, x, y, s, result, es[W-1:0]);
    end
    checks++;
    if (carry_out != es[W]) begin
      failures++;
      $display("FAIL %s carry_out a=%h b=%h s=%0b actual=%0b expected=%0b", req, x, y, s, carry_out, es[W]);
    end
    checks++;
    if (overflow != eo) begin
      failures++;
      $display("FAIL R4 %s overflow a=%h b=%h s=%0b actual=%0b expected=%0b", req, x, y, s, overflow, eo);
    end
    checks++;
    if (result[0] != (x[0] ^ y[0])) begin
      failures++;
      $display("FAIL R8 low bit a=%h b=%h actual=%0b expected=%0b", x, y, result[0], x[0] ^ y[0]);
    end
  endtask

  task automatic expect_bit(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; sub = 1'b0;
    @(negedge clk);
    expect_bit(result == '0, 1'b1, "R9 result zero");
    expect_bit(carry_out, 1'b0, "R9 carry_out zero");
    expect_bit(overflow, 1'b0, "R9 overflow zero");

    // R1 directed additions
    apply(13'h0123, 13'h0456, 1'b0, "R1");
    apply(13'h1FFF, 13'h0001, 1'b0, "R5");
    expect_bit(result == 13'h0000 && carry_out, 1'b1, "R5 full carry");
    apply(13'h0FFF, 13'h0001, 1'b0, "R7");
    expect_bit(overflow, 1'b1, "R7 positive overflow");
    apply(13'h1000, 13'h1000, 1'b0, "R1");
    expect_bit(carry_out & overflow, 1'b1, "R4 carry and overflow together");
    apply(13'h0AAA, 13'h1555, 1'b0, "R1");

    // R2 directed subtractions
    apply(13'h0000, 13'h0001, 1'b1, "R6");
    expect_bit(result == 13'h1FFF && !carry_out, 1'b1, "R6 full borrow");
    apply(13'h1000, 13'h0001, 1'b1, "R7");
    expect_bit(overflow, 1'b1, "R7 negative overflow");
    apply(13'h0500, 13'h0500, 1'b1, "R3");
    expect_bit(carry_out, 1'b1, "R3 equal operands no borrow");
    apply(13'h0FFF, 13'h1FFF, 1'b1, "R2");
    apply(13'h1234, 13'h0234, 1'b1, "R2");

    void'($urandom(32'h5EED));
    for (int n = 0; n < NRAND; n++) begin
      logic [W-1:0] x, y;
      logic s;
      x = W'($urandom());
      y = W'($urandom());
      s = 1'($urandom());
      if (n % 64 == 0) y = ~x;
      apply(x, y, s, s ? "R2/R3 random" : "R1 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule